// File: doc/BRIEF.md
# Multi-Channel Driver Fault Supervisor

This block stands between the command register set of a multi-output driver and its twelve power switches. The switches form six half-bridge pairs, each with a high side and a low side. Each cycle it combines three things into the enables actually applied to the switches: the commanded enables, the protection policy bits, and per-channel digital fault flags. It also keeps four sticky status flags that software reads and clears with a status-reset pulse.

The faults fall into two groups. Over-current and a sustained under-load are per-channel faults. When their policy bit allows it, they switch off only the offending channel, and the channel stays off until a status reset. Supply overvoltage (when its shutdown policy is on) and over-temperature on any of the six thermal sensors are global faults. They blank every output for as long as they last, then restore the programmed selection without software help. Thermal warnings only raise a status flag. An undervoltage on the logic supply wipes all state. Shoot-through between the two switches of a pair is not prevented here; avoiding it is left to software.

Top module: `drv_fault_supervisor`

## Requirements
- R1: After reset, and in every cycle after an edge where `logicUv` was high, all of `drvEn`, `stOc`, `stUl`, `stOv` and `stTw` are 0. Every channel latch-off and under-load count is also cleared.
- R2: With no fault active, `drvEn` equals the `cmdEn` value sampled at the previous clock edge. Bit p (0..5) is the high side of pair p and bit p+6 is its low side.
- R3: An `ocFlag` bit that is high at an edge while its channel's `drvEn` is 1 sets `stOc` at that edge. `stOc` then stays 1 until a `statusClr` or `logicUv`.
- R4: With `ocLatchEn`=1, such an over-current forces that channel's `drvEn` to 0 from the same edge on, until `statusClr`. With `ocLatchEn`=0, the channel's enable is unchanged.
- R5: A channel counts under-load on each edge where its `ulFlag` and `drvEn` are both 1. The count restarts when either is 0. `stUl` is set on the edge where the flag is seen for the (UL_DELAY+1)-th consecutive edge, and it stays set until `statusClr`.
- R6: With `ulLatchEn`=1, the channel that raises an under-load fault is latched off until `statusClr`. With `ulLatchEn`=0, its enable is unchanged.
- R7: Either bit of `vsOver` sets `stOv`, which is sticky until `statusClr`. If `ovShutEn`=1, every `drvEn` is 0 while `vsOver` is nonzero, and the programmed enables return on the first edge after it clears.
- R8: Any `twFlag` bit sets `stTw`, which stays 1 after the flag drops until `statusClr`. The outputs are not affected.
- R9: Any `otFlag` bit forces all `drvEn` to 0. When every bit is 0 again, the outputs return to `cmdEn` minus the latched-off channels, and the latches are unchanged.
- R10: `ocFlag` and `ulFlag` on a channel whose `drvEn` is 0 change no status bit and no latch.
- R11: `statusClr` clears all four status bits and all channel latches. A fault detected at the same edge wins and is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| logicUv | input | 1 | Logic supply undervoltage: wipes all state and holds outputs off |
| cmdEn | input | 12 | Commanded driver enables |
| ocLatchEn | input | 1 | Policy: latch off a channel on over-current |
| ulLatchEn | input | 1 | Policy: latch off a channel on under-load |
| ovShutEn | input | 1 | Policy: blank all outputs during overvoltage |
| statusClr | input | 1 | Status-reset pulse |
| ocFlag | input | 12 | Per-channel over-current flags |
| ulFlag | input | 12 | Per-channel under-load flags |
| vsOver | input | 2 | Overvoltage flags, one per power supply |
| twFlag | input | 6 | Thermal warning per pair sensor |
| otFlag | input | 6 | Over-temperature per pair sensor |
| drvEn | output | 12 | Effective driver enables |
| stOc | output | 1 | Sticky over-current status |
| stUl | output | 1 | Sticky under-load status |
| stOv | output | 1 | Sticky overvoltage status |
| stTw | output | 1 | Sticky thermal warning status |

## Verification
The in-line assertions check several properties on every cycle. Outputs never enable a channel that was not commanded. A global blank leaves every output off. A latched channel stays latched without a clear. The over-current and thermal-warning flags stay sticky. No under-load count passes its limit. A wipe empties all state. Other behaviours can only be shown by the bench's scenarios against its reference model: the exact edge on which an under-load fault fires, including a restart after the flag drops, the restore of the programmed selection after overvoltage or over-temperature, the rule that a fault wins over a same-edge clear, and the rule that a disabled channel's faults are ignored.

// File: rtl/fsup_pkg.sv
package fsup_pkg;

  // Strobes from the control half to the channel datapath
  typedef struct packed {
    logic wipe;    // logic supply undervoltage: clear everything
    logic clr;     // status reset: release latched channels
    logic blank;   // global blanking (overvoltage policy or over-temperature)
    logic ocKill;  // over-current latches the channel off
    logic ulKill;  // under-load latches the channel off
  } fsup_strobe_t;

endpackage

// File: rtl/fsup_datapath.sv
module fsup_datapath
  import fsup_pkg::*;
#(
  parameter int NUM_CH   = 12,
  parameter int UL_DELAY = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  fsup_strobe_t      stb,
  input  logic [NUM_CH-1:0] cmdEn,
  input  logic [NUM_CH-1:0] ocFlag,
  input  logic [NUM_CH-1:0] ulFlag,
  output logic [NUM_CH-1:0] drvEn,
  output logic [NUM_CH-1:0] ocHit,
  output logic [NUM_CH-1:0] ulHit
);

  localparam int CW = $clog2(UL_DELAY + 1);

  logic [NUM_CH-1:0] latchOff;
  logic [NUM_CH-1:0] latchNext;
  logic [NUM_CH-1:0] drvNext;

  // faults only count on channels that are actually driving
  assign ocHit = ocFlag & drvEn;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [CW-1:0] ulCnt;
    logic          ulActive;

    assign ulActive  = ulFlag[ch] & drvEn[ch];
    assign ulHit[ch] = ulActive && (ulCnt == CW'(UL_DELAY));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ulCnt <= '0;
      end else if (stb.wipe || !ulActive) begin
        ulCnt <= '0;
      end else if (ulCnt != CW'(UL_DELAY)) begin
        ulCnt <= ulCnt + 1'b1;
      end
    end

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
      ulCnt <= CW'(UL_DELAY));
  end

  always_comb begin
    if (stb.wipe) begin
      latchNext = '0;
    end else begin
      latchNext = (latchOff & ~{NUM_CH{stb.clr}})
                | (ocHit & {NUM_CH{stb.ocKill}})
                | (ulHit & {NUM_CH{stb.ulKill}});
    end
    if (stb.wipe || stb.blank) begin
      drvNext = '0;
    end else begin
      drvNext = cmdEn & ~latchNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchOff <= '0;
      drvEn    <= '0;
    end else begin
      latchOff <= latchNext;
      drvEn    <= drvNext;
    end
  end

  // R2
  no_uncommanded_chk: assert property (@(posedge clk) disable iff (!rstN)
    (drvEn & ~$past(cmdEn)) == '0);

  // R4
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.clr && !stb.wipe) |=> ((latchOff & $past(latchOff)) == $past(latchOff)));

  // R9
  blank_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.blank |=> (drvEn == '0));

  // R1
  wipe_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wipe |=> (drvEn == '0 && latchOff == '0));

endmodule

// File: rtl/fsup_control.sv
module fsup_control
  import fsup_pkg::*;
#(
  parameter int NUM_CH    = 12,
  parameter int NUM_PAIRS = 6,
  parameter int NUM_SUP   = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 logicUv,
  input  logic                 statusClr,
  input  logic                 ocLatchEn,
  input  logic                 ulLatchEn,
  input  logic                 ovShutEn,
  input  logic [NUM_SUP-1:0]   vsOver,
  input  logic [NUM_PAIRS-1:0] twFlag,
  input  logic [NUM_PAIRS-1:0] otFlag,
  input  logic [NUM_CH-1:0]    ocHit,
  input  logic [NUM_CH-1:0]    ulHit,
  output fsup_strobe_t         stb,
  output logic                 stOc,
  output logic                 stUl,
  output logic                 stOv,
  output logic                 stTw
);

  localparam int NUM_ST = 4;

  logic [NUM_ST-1:0] stSet;
  logic [NUM_ST-1:0] stReg;

  always_comb begin
    stb.wipe   = logicUv;
    stb.clr    = statusClr;
    stb.blank  = (ovShutEn & (|vsOver)) | (|otFlag);
    stb.ocKill = ocLatchEn;
    stb.ulKill = ulLatchEn;
  end

  assign stSet = {|ocHit, |ulHit, |vsOver, |twFlag};

  for (genvar b = 0; b < NUM_ST; b++) begin : g_stat
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stReg[b] <= 1'b0;
      end else if (logicUv) begin
        stReg[b] <= 1'b0;
      end else begin
        stReg[b] <= (stReg[b] & ~statusClr) | stSet[b];
      end
    end
  end

  assign {stOc, stUl, stOv, stTw} = stReg;

  // R3
  oc_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stOc && !statusClr && !logicUv) |=> stOc);

  // R8
  tw_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stTw && !statusClr && !logicUv) |=> stTw);

  // R7
  ov_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stOv && !statusClr && !logicUv) |=> stOv);

endmodule

// File: rtl/drv_fault_supervisor.sv
module drv_fault_supervisor
  import fsup_pkg::*;
#(
  parameter int NUM_PAIRS = 6,
  parameter int NUM_SUP   = 2,
  parameter int UL_DELAY  = 8,
  localparam int NUM_CH   = 2 * NUM_PAIRS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 logicUv,
  input  logic [NUM_CH-1:0]    cmdEn,
  input  logic                 ocLatchEn,
  input  logic                 ulLatchEn,
  input  logic                 ovShutEn,
  input  logic                 statusClr,
  input  logic [NUM_CH-1:0]    ocFlag,
  input  logic [NUM_CH-1:0]    ulFlag,
  input  logic [NUM_SUP-1:0]   vsOver,
  input  logic [NUM_PAIRS-1:0] twFlag,
  input  logic [NUM_PAIRS-1:0] otFlag,
  output logic [NUM_CH-1:0]    drvEn,
  output logic                 stOc,
  output logic                 stUl,
  output logic                 stOv,
  output logic                 stTw
);

  fsup_strobe_t      stb;
  logic [NUM_CH-1:0] ocHit;
  logic [NUM_CH-1:0] ulHit;

  fsup_control #(
    .NUM_CH(NUM_CH), .NUM_PAIRS(NUM_PAIRS), .NUM_SUP(NUM_SUP)
  ) u_control (
    .clk(clk), .rstN(rstN), .logicUv(logicUv), .statusClr(statusClr),
    .ocLatchEn(ocLatchEn), .ulLatchEn(ulLatchEn), .ovShutEn(ovShutEn),
    .vsOver(vsOver), .twFlag(twFlag), .otFlag(otFlag),
    .ocHit(ocHit), .ulHit(ulHit), .stb(stb),
    .stOc(stOc), .stUl(stUl), .stOv(stOv), .stTw(stTw)
  );

  fsup_datapath #(
    .NUM_CH(NUM_CH), .UL_DELAY(UL_DELAY)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdEn(cmdEn),
    .ocFlag(ocFlag), .ulFlag(ulFlag),
    .drvEn(drvEn), .ocHit(ocHit), .ulHit(ulHit)
  );

endmodule

// File: tb/drv_fault_supervisor_bench.sv
`timescale 1ns/1ps
module drv_fault_supervisor_bench;

  localparam int NP = 6;
  localparam int NC = 12;
  localparam int UL = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic logicUv = 1'b0;
  logic [NC-1:0] cmdEn = '0;
  logic ocLatchEn = 1'b0, ulLatchEn = 1'b0, ovShutEn = 1'b0, statusClr = 1'b0;
  logic [NC-1:0] ocFlag = '0, ulFlag = '0;
  logic [1:0] vsOver = '0;
  logic [NP-1:0] twFlag = '0, otFlag = '0;
  logic [NC-1:0] drvEn;
  logic stOc, stUl, stOv, stTw;

  always #2.5 clk = ~clk;

  drv_fault_supervisor #(.NUM_PAIRS(NP), .NUM_SUP(2), .UL_DELAY(UL)) u_drv_fault_supervisor (
    .clk(clk), .rstN(rstN), .logicUv(logicUv), .cmdEn(cmdEn),
    .ocLatchEn(ocLatchEn), .ulLatchEn(ulLatchEn), .ovShutEn(ovShutEn),
    .statusClr(statusClr), .ocFlag(ocFlag), .ulFlag(ulFlag), .vsOver(vsOver),
    .twFlag(twFlag), .otFlag(otFlag), .drvEn(drvEn),
    .stOc(stOc), .stUl(stUl), .stOv(stOv), .stTw(stTw)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit run = 0;
  string curReq = "R1";

  // behavioural reference model
  logic [NC-1:0] mDrv = '0, mLatch = '0;
  int mCnt [NC];
  logic [3:0] mStat = '0;  // {oc, ul, ov, tw}

  initial for (int i = 0; i < NC; i++) mCnt[i] = 0;

  always @(posedge clk) begin
    logic [NC-1:0] ocH, ulH;
    bit blank;
    if (!rstN || logicUv) begin
      mDrv = '0; mLatch = '0; mStat = '0;
      for (int i = 0; i < NC; i++) mCnt[i] = 0;
    end else begin
      ocH = ocFlag & mDrv;
      ulH = '0;
      for (int i = 0; i < NC; i++) begin
        if (ulFlag[i] && mDrv[i]) begin
          if (mCnt[i] == UL) ulH[i] = 1'b1;
          else mCnt[i] = mCnt[i] + 1;
        end else begin
          mCnt[i] = 0;
        end
      end
      if (statusClr) begin
        mLatch = '0;
        mStat = '0;
      end
      if (ocLatchEn) mLatch = mLatch | ocH;
      if (ulLatchEn) mLatch = mLatch | ulH;
      mStat = mStat | {ocH != 0, ulH != 0, vsOver != 0, twFlag != 0};
      blank = (ovShutEn && vsOver != 0) || (otFlag != 0);
      mDrv = blank ? '0 : (cmdEn & ~mLatch);
    end
  end

  task automatic check(string req, logic [15:0] got, logic [15:0] exp, string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, got, exp, $time);
    end
  endtask

  // compare against the model on every cycle, away from the active edge
  always @(negedge clk) begin
    if (run) begin
      check(curReq, 16'(drvEn), 16'(mDrv), "drvEn vs model");
      check(curReq, 16'({stOc, stUl, stOv, stTw}), 16'(mStat), "status vs model");
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseClr();
    statusClr = 1'b1; tick(1); statusClr = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    // R1 reset state
    check("R1", 16'({drvEn, stOc, stUl, stOv, stTw}), 16'h0, "reset outputs");
    rstN = 1'b1;
    tick(1);
    run = 1;

    // R2 plain follow, several patterns
    curReq = "R2";
    cmdEn = 12'hFFF; tick(1);
    check("R2", 16'(drvEn), 16'hFFF, "all on");
    cmdEn = 12'h03F; tick(1);
    check("R2", 16'(drvEn), 16'h03F, "high sides only");
    cmdEn = 12'hA5A; tick(3);
    cmdEn = 12'hFFF; tick(2);

    // R3 over-current without latch-off
    curReq = "R3";
    ocFlag = 12'h008; tick(1); ocFlag = '0;
    check("R3", 16'(stOc), 16'h1, "oc status set");
    check("R4", 16'(drvEn), 16'hFFF, "no latch when policy off");
    tick(4);
    check("R3", 16'(stOc), 16'h1, "oc status sticky");
    curReq = "R11"; pulseClr();
    check("R11", 16'(stOc), 16'h0, "oc status cleared");

    // R4 latch-off
    curReq = "R4";
    ocLatchEn = 1'b1;
    ocFlag = 12'h080; tick(1); ocFlag = '0;
    check("R4", 16'(drvEn), 16'hF7F, "channel 7 latched off");
    cmdEn = 12'h0FF; tick(2); cmdEn = 12'hFFF; tick(2);
    check("R4", 16'(drvEn), 16'hF7F, "still latched");
    curReq = "R11"; pulseClr(); tick(1);
    check("R11", 16'(drvEn), 16'hFFF, "released by clear");

    // R10 faults on a disabled channel
    curReq = "R10";
    ulLatchEn = 1'b1;
    cmdEn = 12'hFFB; tick(1);
    ocFlag = 12'h004; ulFlag = 12'h004; tick(UL + 6);
    ocFlag = '0; ulFlag = '0;
    check("R10", 16'({stOc, stUl}), 16'h0, "disabled channel ignored");
    cmdEn = 12'hFFF; ulLatchEn = 1'b0; tick(1);
    check("R10", 16'(drvEn), 16'hFFF, "no latch on disabled channel");

    // R5 under-load delay with restart
    curReq = "R5";
    ulFlag = 12'h002; tick(UL);
    ulFlag = '0; tick(1);
    check("R5", 16'(stUl), 16'h0, "short under-load ignored");
    ulFlag = 12'h002; tick(UL);
    check("R5", 16'(stUl), 16'h0, "UL_DELAY edges not enough");
    tick(1);
    check("R5", 16'(stUl), 16'h1, "fires on next edge");
    ulFlag = '0;
    check("R6", 16'(drvEn), 16'hFFF, "no latch when policy off");
    tick(2); pulseClr();

    // R6 under-load latch-off
    curReq = "R6";
    ulLatchEn = 1'b1;
    ulFlag = 12'h200; tick(UL + 1);
    check("R6", 16'(drvEn), 16'hDFF, "channel 9 latched off");
    ulFlag = '0; tick(3);
    check("R6", 16'(drvEn), 16'hDFF, "stays off");

    // R7 overvoltage
    curReq = "R7";
    vsOver = 2'b01; tick(2);
    check("R7", 16'(drvEn), 16'hDFF, "no blank with policy off");
    vsOver = 2'b00; tick(1);
    check("R7", 16'(stOv), 16'h1, "ov status sticky");
    ovShutEn = 1'b1; vsOver = 2'b10; tick(1);
    check("R7", 16'(drvEn), 16'h000, "blanked");
    tick(3); vsOver = 2'b00; tick(1);
    check("R7", 16'(drvEn), 16'hDFF, "restored");

    // R8 thermal warning
    curReq = "R8";
    twFlag = 6'h10; tick(2); twFlag = '0; tick(2);
    check("R8", 16'(stTw), 16'h1, "warning latched after cooling");
    check("R8", 16'(drvEn), 16'hDFF, "outputs untouched");

    // R9 over-temperature with a latched channel present
    curReq = "R9";
    otFlag = 6'h20; tick(1);
    check("R9", 16'(drvEn), 16'h000, "all off");
    otFlag = 6'h21; tick(2); otFlag = 6'h01; tick(2);
    check("R9", 16'(drvEn), 16'h000, "off until every sensor clears");
    otFlag = '0; tick(1);
    check("R9", 16'(drvEn), 16'hDFF, "selection restored, latch kept");

    // R11 fault at the same edge as clear wins
    curReq = "R11";
    ocFlag = 12'h001; statusClr = 1'b1; tick(1);
    ocFlag = '0; statusClr = 1'b0;
    check("R11", 16'(stOc), 16'h1, "same-edge fault kept");
    check("R11", 16'(drvEn), 16'hFFE, "latch 9 cleared, 0 set");
    check("R11", 16'({stUl, stOv, stTw}), 16'h0, "others cleared");

    // R1 undervoltage wipe
    curReq = "R1";
    logicUv = 1'b1; tick(1);
    check("R1", 16'({drvEn, stOc, stUl, stOv, stTw}), 16'h0, "wiped");
    logicUv = 1'b0; tick(1);
    check("R1", 16'(drvEn), 16'hFFF, "latch gone after wipe");
    tick(4);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule